// File: doc/BRIEF.md
# I2C Controller Register File and Interrupt Unit

This block is the software-facing side of an I2C master controller. It holds the memory-mapped registers that the transfer engine runs from: two clock-setting words, a configuration word, a command word, a target address and a 64-bit data buffer. It also holds the interrupt status, the interrupt mask and a busy indication. Bus accesses arrive as single-cycle read or write strobes with a byte offset. Reads return data combinationally in the same cycle. Writes take effect at the next clock edge.

The transfer engine reports each outcome as a one-cycle event on a five-bit vector. These events are latched into sticky status flags, and software clears them by writing ones. The engine sets the done flag at the end of every transaction, whether it succeeded or failed. Software can therefore unmask done alone, take one interrupt per transfer and still read every error cause from the status word. The status word also carries a prioritized result code, so the outcome is available in a single read.

A write to the command word while the controller is idle launches a transfer. The launch is signalled by a one-cycle strobe to the engine, and busy then reads one until the engine reports done. A command written while busy is dropped and recorded as a bus-busy failure.

Top module: `i2c_regs_top`

## Requirements
- R1: After reset the registers read as follows: both clock words 0x301F, configuration 0x3302, and command, address, data, status, mask and busy all zero. The irq and startPulse outputs are low while reset is held and after it is released.
- R2: Word offsets decode as 0x00 standard clock, 0x04 high-speed clock, 0x08 configuration, 0x0C command, 0x10 address, 0x14 data low, 0x18 data high, 0x1C status, 0x20 mask and 0x24 busy. Only these bits are writable and read back: clock words bits 15:12 and 9:0; configuration bits 15:4, 1 and 0; command bits 9:8, 6:4 and 2:0; address bits 9:0; data words all 32 bits; mask bits 4:0.
- R3: A read at a misaligned offset or an offset above 0x24 returns zero. A write there changes no register.
- R4: Status bits 4:0 are done (0), lost arbitration (1), no response (2), data collision (3) and bus busy (4). An engine event on engEvt bit k sets status bit k, and the bit stays set afterwards.
- R5: A write to the status offset clears exactly those status bits that are one in the written value. Bits written as zero are left unchanged.
- R6: If an engine event sets a status bit in the same cycle that software writes a one to clear it, the bit remains set.
- R7: irq is high exactly when some status bit is set and its mask bit is one. The mask resets to zero.
- R8: A command write while busy reads zero stores the command and drives startPulse high for exactly the one cycle after the write. Busy (offset 0x24, bit 0) reads one from that cycle until the cycle after an engine done event.
- R9: A command write while busy reads one is dropped. No startPulse is produced, the command register keeps its value, and status bits done and bus busy are set.
- R10: Status bits 10:8 hold a result code chosen by priority: 1 lost arbitration, else 2 no response, else 3 data collision, else 4 bus busy, else 0 for success.
- R11: When engRxValid is high, engRxData bits 31:0 load the data low word and bits 63:32 load the data high word. This load takes precedence over a software write to those words in the same cycle.
- R12: The outputs stdClkCfg, hsClkCfg, cfgWord, cmdWord, slaveAddr and txData always equal the current register contents. txData is {data high, data low}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Single-cycle write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational, zero when no read is selected |
| engEvt | input | 5 | Engine outcome events, bit positions as in status |
| engRxValid | input | 1 | Engine delivers received data |
| engRxData | input | 64 | Received data |
| stdClkCfg | output | 16 | Standard/fast clock word |
| hsClkCfg | output | 16 | High-speed clock word |
| cfgWord | output | 16 | Configuration word |
| cmdWord | output | 16 | Command word |
| slaveAddr | output | 10 | Target address |
| txData | output | 64 | Transmit data buffer |
| startPulse | output | 1 | One-cycle transfer launch strobe |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a collision at one clock edge. An engine event, a software write-one-to-clear to the same bit and a command write that arrives while busy can all land on that edge. The directed part of the stimulus sets up each of these on purpose: it clears a flag in the very cycle its event fires, and it issues a second command before done has come back. A long stretch of random accesses then mixes writes to the status and command offsets with sparse engine events and data loads. A behavioural model, compared every cycle, catches any ordering mistake at those edges.

// File: rtl/i2c_regs_pkg.sv
`timescale 1ns/1ps
package i2c_regs_pkg;

  localparam int STS_W     = 5;
  localparam int NUM_REGS  = 10;

  localparam int STS_DONE    = 0;
  localparam int STS_ARB     = 1;
  localparam int STS_NORESP  = 2;
  localparam int STS_COLL    = 3;
  localparam int STS_BUSBUSY = 4;

  localparam logic [15:0] CLK_WMASK = 16'hF3FF;
  localparam logic [15:0] CLK_RST   = 16'h301F;
  localparam logic [15:0] CFG_WMASK = 16'hFFF3;
  localparam logic [15:0] CFG_RST   = 16'h3302;
  localparam logic [15:0] CMD_WMASK = 16'h0377;

  // register select; order follows the word offsets (index + 1)
  typedef enum logic [3:0] {
    SEL_NONE   = 4'd0,
    SEL_STDCLK = 4'd1,
    SEL_HSCLK  = 4'd2,
    SEL_CFG    = 4'd3,
    SEL_CMD    = 4'd4,
    SEL_ADDR   = 4'd5,
    SEL_DATLO  = 4'd6,
    SEL_DATHI  = 4'd7,
    SEL_STS    = 4'd8,
    SEL_MASK   = 4'd9,
    SEL_BUSY   = 4'd10
  } regSel_e;

  typedef struct packed {
    logic wrStdClk;
    logic wrHsClk;
    logic wrCfg;
    logic cmdAccept;
    logic cmdReject;
    logic wrAddr;
    logic wrDatLo;
    logic wrDatHi;
    logic clrSts;
    logic wrMask;
  } ctlStrobe_t;

  function automatic logic [2:0] resultOf(input logic [STS_W-1:0] s);
    if (s[STS_ARB])          return 3'd1;
    else if (s[STS_NORESP])  return 3'd2;
    else if (s[STS_COLL])    return 3'd3;
    else if (s[STS_BUSBUSY]) return 3'd4;
    else                     return 3'd0;
  endfunction

endpackage

// File: rtl/i2c_regs_ctl.sv
`timescale 1ns/1ps
module i2c_regs_ctl
  import i2c_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              engDoneEvt,
  output ctlStrobe_t        strb,
  output regSel_e           rdSel,
  output logic              startPulse,
  output logic              busyNow
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  regSel_e          hitSel;
  logic             busyQ;
  logic             startQ;
  logic             cmdHit;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    if (aligned && (int'(wordIdx) < NUM_REGS))
      hitSel = regSel_e'(4'(int'(wordIdx) + 1));
    else
      hitSel = SEL_NONE;
  end

  assign cmdHit = busWrEn && (hitSel == SEL_CMD);

  always_comb begin
    strb           = '0;
    strb.wrStdClk  = busWrEn && (hitSel == SEL_STDCLK);
    strb.wrHsClk   = busWrEn && (hitSel == SEL_HSCLK);
    strb.wrCfg     = busWrEn && (hitSel == SEL_CFG);
    strb.cmdAccept = cmdHit && !busyQ;
    strb.cmdReject = cmdHit && busyQ;
    strb.wrAddr    = busWrEn && (hitSel == SEL_ADDR);
    strb.wrDatLo   = busWrEn && (hitSel == SEL_DATLO);
    strb.wrDatHi   = busWrEn && (hitSel == SEL_DATHI);
    strb.clrSts    = busWrEn && (hitSel == SEL_STS);
    strb.wrMask    = busWrEn && (hitSel == SEL_MASK);
  end

  assign rdSel = busRdEn ? hitSel : SEL_NONE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      startQ <= 1'b0;
    end else begin
      startQ <= strb.cmdAccept;
      if (strb.cmdAccept)
        busyQ <= 1'b1;
      else if (engDoneEvt)
        busyQ <= 1'b0;
    end
  end

  assign startPulse = startQ;
  assign busyNow    = busyQ;

endmodule

// File: rtl/i2c_regs_dp.sv
`timescale 1ns/1ps
module i2c_regs_dp
  import i2c_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  input  regSel_e          rdSel,
  input  logic [31:0]      busWrData,
  input  logic [STS_W-1:0] engEvt,
  input  logic             engRxValid,
  input  logic [63:0]      engRxData,
  input  logic             busyNow,
  output logic [31:0]      busRdData,
  output logic [15:0]      stdClkCfg,
  output logic [15:0]      hsClkCfg,
  output logic [15:0]      cfgWord,
  output logic [15:0]      cmdWord,
  output logic [9:0]       slaveAddr,
  output logic [63:0]      txData,
  output logic             irq
);

  logic [15:0]      stdQ, hsQ, cfgQ, cmdQ;
  logic [9:0]       adrQ;
  logic [31:0]      datLoQ, datHiQ;
  logic [STS_W-1:0] stsQ, maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stdQ  <= CLK_RST;
      hsQ   <= CLK_RST;
      cfgQ  <= CFG_RST;
      cmdQ  <= '0;
      adrQ  <= '0;
      maskQ <= '0;
    end else begin
      if (strb.wrStdClk)  stdQ  <= busWrData[15:0] & CLK_WMASK;
      if (strb.wrHsClk)   hsQ   <= busWrData[15:0] & CLK_WMASK;
      if (strb.wrCfg)     cfgQ  <= busWrData[15:0] & CFG_WMASK;
      if (strb.cmdAccept) cmdQ  <= busWrData[15:0] & CMD_WMASK;
      if (strb.wrAddr)    adrQ  <= busWrData[9:0];
      if (strb.wrMask)    maskQ <= busWrData[STS_W-1:0];
    end
  end

  // data buffer: engine delivery wins over a same-cycle software write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      datLoQ <= '0;
      datHiQ <= '0;
    end else if (engRxValid) begin
      datLoQ <= engRxData[31:0];
      datHiQ <= engRxData[63:32];
    end else begin
      if (strb.wrDatLo) datLoQ <= busWrData;
      if (strb.wrDatHi) datHiQ <= busWrData;
    end
  end

  // sticky flags, one cell per bit; a set always beats a clear
  for (genvar b = 0; b < STS_W; b++) begin : g_sts
    localparam bit REJ_HIT = (b == STS_DONE) || (b == STS_BUSBUSY);
    logic setB;
    logic clrB;
    assign setB = engEvt[b] | (strb.cmdReject & REJ_HIT);
    assign clrB = strb.clrSts & busWrData[b];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     stsQ[b] <= 1'b0;
      else if (setB) stsQ[b] <= 1'b1;
      else if (clrB) stsQ[b] <= 1'b0;
    end
  end

  always_comb begin
    case (rdSel)
      SEL_STDCLK: busRdData = {16'd0, stdQ};
      SEL_HSCLK:  busRdData = {16'd0, hsQ};
      SEL_CFG:    busRdData = {16'd0, cfgQ};
      SEL_CMD:    busRdData = {16'd0, cmdQ};
      SEL_ADDR:   busRdData = {22'd0, adrQ};
      SEL_DATLO:  busRdData = datLoQ;
      SEL_DATHI:  busRdData = datHiQ;
      SEL_STS:    busRdData = {21'd0, resultOf(stsQ), 3'd0, stsQ};
      SEL_MASK:   busRdData = {{(32-STS_W){1'b0}}, maskQ};
      SEL_BUSY:   busRdData = {31'd0, busyNow};
      default:    busRdData = '0;
    endcase
  end

  assign irq       = |(stsQ & maskQ);
  assign stdClkCfg = stdQ;
  assign hsClkCfg  = hsQ;
  assign cfgWord   = cfgQ;
  assign cmdWord   = cmdQ;
  assign slaveAddr = adrQ;
  assign txData    = {datHiQ, datLoQ};

endmodule

// File: rtl/i2c_regs_top.sv
`timescale 1ns/1ps
module i2c_regs_top
  import i2c_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic [4:0]        engEvt,
  input  logic              engRxValid,
  input  logic [63:0]       engRxData,
  output logic [15:0]       stdClkCfg,
  output logic [15:0]       hsClkCfg,
  output logic [15:0]       cfgWord,
  output logic [15:0]       cmdWord,
  output logic [9:0]        slaveAddr,
  output logic [63:0]       txData,
  output logic              startPulse,
  output logic              irq
);

  ctlStrobe_t strb;
  regSel_e    rdSel;
  logic       busyNow;

  i2c_regs_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busAddr    (busAddr),
    .engDoneEvt (engEvt[STS_DONE]),
    .strb       (strb),
    .rdSel      (rdSel),
    .startPulse (startPulse),
    .busyNow    (busyNow)
  );

  i2c_regs_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rdSel      (rdSel),
    .busWrData  (busWrData),
    .engEvt     (engEvt),
    .engRxValid (engRxValid),
    .engRxData  (engRxData),
    .busyNow    (busyNow),
    .busRdData  (busRdData),
    .stdClkCfg  (stdClkCfg),
    .hsClkCfg   (hsClkCfg),
    .cfgWord    (cfgWord),
    .cmdWord    (cmdWord),
    .slaveAddr  (slaveAddr),
    .txData     (txData),
    .irq        (irq)
  );

endmodule

// File: rtl/i2c_regs_chk.sv
`timescale 1ns/1ps
module i2c_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWrData,
  input logic [31:0]       busRdData,
  input logic              startPulse,
  input logic              irq,
  input logic              busyNow
);

  localparam logic [ADDR_W-1:0] CMD_OFS  = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] MASK_OFS = ADDR_W'(32);
  localparam logic [ADDR_W-1:0] LAST_OFS = ADDR_W'(36);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!irq && !startPulse));

  assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && ((busAddr[1:0] != 2'b00) || (busAddr > LAST_OFS))) |-> (busRdData == 32'd0));

  assert_mask_zero_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr == MASK_OFS) && (busWrData[4:0] == 5'd0)) |=> !irq);

  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  assert_start_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(busWrEn && (busAddr == CMD_OFS)));

  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> busyNow);

  assert_reject_no_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr == CMD_OFS) && busyNow) |=> !startPulse);

endmodule

bind i2c_regs_top i2c_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busWrEn    (busWrEn),
  .busRdEn    (busRdEn),
  .busAddr    (busAddr),
  .busWrData  (busWrData),
  .busRdData  (busRdData),
  .startPulse (startPulse),
  .irq        (irq),
  .busyNow    (busyNow)
);

// File: tb/i2c_regs_top_tb.sv
`timescale 1ns/1ps
module i2c_regs_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [4:0]  engEvt = '0;
  logic        engRxValid = 1'b0;
  logic [63:0] engRxData = '0;
  logic [15:0] stdClkCfg, hsClkCfg, cfgWord, cmdWord;
  logic [9:0]  slaveAddr;
  logic [63:0] txData;
  logic        startPulse, irq;

  int nChecks = 0;
  int nErrs   = 0;

  // behavioural reference state
  logic [15:0] mStd = 16'h301F, mHs = 16'h301F, mCfg = 16'h3302, mCmd = 16'h0;
  logic [9:0]  mAdr = '0;
  logic [31:0] mDlo = '0, mDhi = '0;
  logic [4:0]  mSts = '0, mMask = '0;
  logic        mBusy = 1'b0, mStart = 1'b0;

  always #2.5 clk = ~clk;

  i2c_regs_top #(.ADDR_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .engEvt(engEvt), .engRxValid(engRxValid),
    .engRxData(engRxData), .stdClkCfg(stdClkCfg), .hsClkCfg(hsClkCfg), .cfgWord(cfgWord),
    .cmdWord(cmdWord), .slaveAddr(slaveAddr), .txData(txData), .startPulse(startPulse), .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] prio(input logic [4:0] s);
    logic [2:0] r;
    r = 3'd0;
    if (s[4]) r = 3'd4;
    if (s[3]) r = 3'd3;
    if (s[2]) r = 3'd2;
    if (s[1]) r = 3'd1;
    return r;
  endfunction

  function automatic logic [31:0] modelRead(input logic [7:0] ad);
    case (ad)
      8'h00: return {16'd0, mStd};
      8'h04: return {16'd0, mHs};
      8'h08: return {16'd0, mCfg};
      8'h0C: return {16'd0, mCmd};
      8'h10: return {22'd0, mAdr};
      8'h14: return mDlo;
      8'h18: return mDhi;
      8'h1C: return {21'd0, prio(mSts), 3'd0, mSts};
      8'h20: return {27'd0, mMask};
      8'h24: return {31'd0, mBusy};
      default: return 32'd0;
    endcase
  endfunction

  task automatic step(input string tag, input bit we, input bit re, input logic [7:0] ad,
                      input logic [31:0] wd, input logic [4:0] ev = 5'd0,
                      input bit rxv = 1'b0, input logic [63:0] rxd = 64'd0);
    bit acc, rej;
    logic [4:0] setV, clrV;
    busWrEn = we; busRdEn = re; busAddr = ad; busWrData = wd;
    engEvt = ev; engRxValid = rxv; engRxData = rxd;
    #1;
    if (re) check(tag, {32'd0, busRdData}, {32'd0, modelRead(ad)});
    acc  = we && (ad == 8'h0C) && !mBusy;
    rej  = we && (ad == 8'h0C) && mBusy;
    setV = ev | (rej ? 5'b10001 : 5'b00000);
    clrV = (we && ad == 8'h1C) ? wd[4:0] : 5'b0;
    if (we) begin
      case (ad)
        8'h00: mStd = wd[15:0] & 16'hF3FF;
        8'h04: mHs  = wd[15:0] & 16'hF3FF;
        8'h08: mCfg = wd[15:0] & 16'hFFF3;
        8'h0C: if (acc) mCmd = wd[15:0] & 16'h0377;
        8'h10: mAdr = wd[9:0];
        8'h14: mDlo = wd;
        8'h18: mDhi = wd;
        8'h20: mMask = wd[4:0];
        default: ;
      endcase
    end
    if (rxv) begin mDlo = rxd[31:0]; mDhi = rxd[63:32]; end
    mSts   = (mSts & ~clrV) | setV;
    mBusy  = acc ? 1'b1 : (ev[0] ? 1'b0 : mBusy);
    mStart = acc;
    @(posedge clk);
    @(negedge clk);
    check("R7 irq level", {63'd0, irq}, {63'd0, |(mSts & mMask)});
    check("R8 start strobe", {63'd0, startPulse}, {63'd0, mStart});
    check("R12 engine view", {16'd0, cfgWord, stdClkCfg, hsClkCfg}, {16'd0, mCfg, mStd, mHs});
    check("R12 engine data", txData, {mDhi, mDlo});
    check("R12 cmd/addr", {38'd0, cmdWord, slaveAddr}, {38'd0, mCmd, mAdr});
  endtask

  task automatic wr(input string tag, input logic [7:0] ad, input logic [31:0] wd,
                    input logic [4:0] ev = 5'd0);
    step(tag, 1'b1, 1'b0, ad, wd, ev);
  endtask

  task automatic rd(input string tag, input logic [7:0] ad);
    step(tag, 1'b0, 1'b1, ad, 32'd0);
  endtask

  task automatic evt(input logic [4:0] ev);
    step("R4 event", 1'b0, 1'b0, 8'h00, 32'd0, ev);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrs);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nChecks++;
    nErrs++;
    $display("FAIL watchdog expired actual running expected finished");
    finishRun();
  end

  initial begin
    // R1 reset
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {63'd0, irq}, 64'd0);
    check("R1 start in reset", {63'd0, startPulse}, 64'd0);
    rstN = 1'b1;
    for (int a = 0; a <= 36; a += 4) rd("R1 reset value", 8'(a));
    check("R1 cfg literal", {48'd0, cfgWord}, 64'h3302);

    // R2 decode and writable fields
    for (int a = 0; a <= 24; a += 4) if (a != 12) wr("R2 write", 8'(a), 32'hFFFF_FFFF);
    wr("R2 mask write", 8'h20, 32'hFFFF_FFE0);
    for (int a = 0; a <= 36; a += 4) rd("R2 readback", 8'(a));
    wr("R2 cfg pattern", 8'h08, 32'h0000_A5A5);
    rd("R2 cfg pattern", 8'h08);
    check("R2 cfg literal", {48'd0, cfgWord}, 64'hA5A1);

    // R3 unmapped offsets
    wr("R3 write high", 8'h28, 32'h1234_5678);
    wr("R3 write misaligned", 8'h09, 32'h0000_0000);
    wr("R3 write top", 8'hFC, 32'hFFFF_FFFF);
    rd("R3 read high", 8'h28);
    rd("R3 read misaligned", 8'h05);
    rd("R3 read top", 8'hFC);
    rd("R3 cfg unchanged", 8'h08);

    // R4, R7, R10: mask done only, errors gathered from one interrupt
    wr("R7 mask done", 8'h20, 32'h1);
    evt(5'b01000);
    check("R7 error alone masked", {63'd0, irq}, 64'd0);
    evt(5'b00110);
    rd("R10 prio arb", 8'h1C);
    evt(5'b00001);
    check("R7 done raises irq", {63'd0, irq}, 64'd1);
    rd("R4 status sticky", 8'h1C);

    // R5 selective clear
    wr("R5 clear done", 8'h1C, 32'h1);
    check("R5 irq dropped", {63'd0, irq}, 64'd0);
    rd("R5 others kept", 8'h1C);
    wr("R10 clear arb", 8'h1C, 32'h2);
    rd("R10 prio noresp", 8'h1C);
    wr("R10 clear noresp", 8'h1C, 32'h4);
    rd("R10 prio coll", 8'h1C);

    // R6 set and clear in one cycle
    wr("R6 set wins", 8'h1C, 32'h1F, 5'b00100);
    rd("R6 set wins", 8'h1C);
    wr("R5 clear all", 8'h1C, 32'h1F);
    rd("R10 success code", 8'h1C);

    // R8 / R9 command launch and rejection
    wr("R8 launch", 8'h0C, 32'h0000_0251);
    check("R8 pulse literal", {63'd0, startPulse}, 64'd1);
    rd("R8 busy high", 8'h24);
    check("R8 pulse one cycle", {63'd0, startPulse}, 64'd0);
    wr("R9 reject", 8'h0C, 32'h0000_0377);
    check("R9 no pulse", {63'd0, startPulse}, 64'd0);
    rd("R9 cmd kept", 8'h0C);
    rd("R9 flags set", 8'h1C);
    check("R9 irq via done", {63'd0, irq}, 64'd1);
    evt(5'b00001);
    rd("R8 busy cleared", 8'h24);
    wr("R5 clear", 8'h1C, 32'h1F);
    wr("R8 relaunch", 8'h0C, 32'h0000_0100);
    evt(5'b00001);

    // R11 engine data load, precedence over software write
    step("R11 load", 1'b1, 1'b0, 8'h14, 32'hDEAD_0000, 5'd0, 1'b1, 64'h0123_4567_89AB_CDEF);
    rd("R11 low", 8'h14);
    rd("R11 high", 8'h18);

    // random mix compared against the model every clock
    for (int i = 0; i < 3000; i++) begin
      int sel;
      logic [7:0] ad;
      bit we;
      logic [4:0] ev;
      sel = int'($urandom % 13);
      ad  = (sel < 11) ? 8'(sel * 4) : ((sel == 11) ? 8'h06 : 8'h40);
      we  = ($urandom % 3) == 0;
      ev  = (($urandom % 5) == 0) ? 5'($urandom) : 5'd0;
      step("R4 random", we, !we, ad, $urandom, ev, (($urandom % 17) == 0),
           {$urandom, $urandom});
    end

    finishRun();
  end

endmodule